// File: doc/BRIEF.md
# Locked Bus Cycle Sequencer

This block sits on the processor side of a 32-bit bus. It takes one transaction at a time from a small internal request port and turns it into one or more bus cycles. A transaction carries a three-bit cycle kind, a lock flag and the number of bus cycles it needs, for example two for a 64-bit descriptor read or four for a 128-bit line fill. For each cycle the block drives an active-low address strobe and the three cycle-kind lines. It keeps the bus lock and pseudo-lock outputs low over the right span of clocks. It reports, at ready time, whether the cycle may become a cache line fill.

A bus-hold request from another master is granted only at a cycle boundary when no lock is in force. While hold is granted, the strobe, kind, lock and pseudo-lock outputs are released through a single drive-enable output. When hold drops, any cycles left in the interrupted transaction resume.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, ads_n, lock_n and plock_n are high, hlda and err are low, and drv_en is high.
- R2: In an idle clock with hold low, req_valid raises req_take in the same clock. The first cycle's ads_n is low in the next clock only. Each cycle lasts until the clock in which rdy_n is sampled low, and the next cycle's ads_n is low in the clock right after that ready.
- R3: cyc_def equals the request kind while ads_n is low. Bit 2 is memory (1) or I/O (0), bit 1 is data (1) or control (0), and bit 0 is write (1) or read (0). The kinds are 000 interrupt acknowledge, 001 halt/special, 010 I/O read, 011 I/O write, 100 code read, 110 memory read and 111 memory write. Kind 101 is reserved: it is taken with err high for that one clock and never starts a cycle.
- R4: For a locked request, lock_n is low from the first address clock through the clock in which the last cycle's ready is sampled, and is high in the next clock.
- R5: plock_n is low during every cycle of a transaction except its last one, and goes high in the clock in which the last cycle's address is driven. A single-cycle transaction never pulls it low.
- R6: Hold is granted (hlda high in the following clock) in an idle clock, or after the ready of a cycle that leaves no lock in force. During a locked transaction, a pending hold waits until after the last ready. In an idle clock, hold takes priority over req_valid.
- R7: hlda stays high while hold stays high, and drv_en is low whenever hlda is high. In the clock after hold drops, hlda is low, and any remaining cycle of the interrupted transaction drives its address in that same clock.
- R8: line_fill is high in a ready clock only when ken_n is low, the kind is code read (100) or memory read (110), and the request is not locked.
- R9: A requested cycle count of zero runs as a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transaction request present |
| req_type | input | 3 | Cycle kind: memory/IO, data/control, write/read |
| req_lock | input | 1 | Transaction is locked |
| req_beats | input | CNT_W | Number of bus cycles (0 treated as 1) |
| req_take | output | 1 | Request consumed this clock |
| err | output | 1 | Consumed request had the reserved kind |
| rdy_n | input | 1 | Active-low ready, ends the current cycle |
| ken_n | input | 1 | Active-low cache enable |
| hold | input | 1 | Bus-hold request |
| hlda | output | 1 | Bus-hold acknowledge |
| ads_n | output | 1 | Active-low address strobe |
| cyc_def | output | 3 | Cycle-kind lines |
| lock_n | output | 1 | Active-low bus lock |
| plock_n | output | 1 | Active-low pseudo-lock |
| drv_en | output | 1 | Output enable for strobe, kind, lock and pseudo-lock |
| line_fill | output | 1 | Current ready may be treated as a cache fill |

## Verification
The assertions assume that rdy_n is meaningful only in the data phase of a cycle. They also assume that hold, once raised, stays up until hlda has been seen, so that a hold grant always follows a hold request. The bench changes every input only on the falling clock edge. It drives ready only after an address clock has passed. It keeps hold high through each grant and drops it only after checking the acknowledge. The sweep over all kinds, lock settings, cycle counts and wait states stays inside these conditions.

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_type,
  input  logic             req_lock,
  input  logic [CNT_W-1:0] req_beats,
  output logic             req_take,
  output logic             err,
  input  logic             rdy_n,
  input  logic             ken_n,
  input  logic             hold,
  output logic             hlda,
  output logic             ads_n,
  output logic [2:0]       cyc_def,
  output logic             lock_n,
  output logic             plock_n,
  output logic             drv_en,
  output logic             line_fill
);

  localparam logic [2:0]       KIND_RSVD = 3'b101;
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_HELD} state_t;

  state_t           state_q;
  logic [2:0]       type_q;
  logic             lock_q;
  logic [CNT_W-1:0] left_q;

  wire idle   = state_q == S_IDLE;
  wire in_adr = state_q == S_ADDR;
  wire in_dat = state_q == S_DATA;
  wire held   = state_q == S_HELD;
  wire busy   = in_adr | in_dat;
  wire ready  = in_dat & ~rdy_n;
  wire last   = left_q == ONE;

  assign req_take  = idle & ~hold & req_valid;
  assign err       = req_take & (req_type == KIND_RSVD);
  assign hlda      = held;
  assign drv_en    = ~held;
  assign ads_n     = ~in_adr;
  assign cyc_def   = type_q;
  assign lock_n    = ~(busy & lock_q);
  assign plock_n   = ~(busy & (left_q > ONE));
  assign line_fill = ready & ~ken_n & ~lock_q & type_q[2] & ~type_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      type_q  <= '0;
      lock_q  <= 1'b0;
      left_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (hold) state_q <= S_HELD;
          else if (req_take && !err) begin
            state_q <= S_ADDR;
            type_q  <= req_type;
            lock_q  <= req_lock;
            left_q  <= (req_beats == '0) ? ONE : req_beats;
          end
        end
        S_ADDR: state_q <= S_DATA;
        S_DATA: begin
          if (!rdy_n) begin
            left_q <= left_q - ONE;
            if (last) lock_q <= 1'b0;
            if (hold && (last || !lock_q)) state_q <= S_HELD;
            else if (last)                 state_q <= S_IDLE;
            else                           state_q <= S_ADDR;
          end
        end
        S_HELD: begin
          if (!hold) state_q <= (left_q != '0) ? S_ADDR : S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_strobe_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |=> ads_n);

  assert_no_reserved_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |-> cyc_def != KIND_RSVD);

  assert_lock_ends_on_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_n) |-> $past(!rdy_n));

  assert_grant_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> ($past(hold) && ($past(lock_n) || $past(!rdy_n))));

  assert_released_when_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !drv_en);

  assert_no_fill_when_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_n |-> !line_fill);

endmodule

// File: tb/tb_bus_cycle_seq.sv
`timescale 1ns/1ps
module tb_bus_cycle_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_lock = 1'b0;
  logic [2:0] req_type = '0, req_beats = '0;
  logic rdy_n = 1'b1, ken_n = 1'b1, hold = 1'b0;
  logic req_take, err, hlda, ads_n, lock_n, plock_n, drv_en, line_fill;
  logic [2:0] cyc_def;
  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_cycle_seq #(.CNT_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_lock(req_lock), .req_beats(req_beats), .req_take(req_take), .err(err),
    .rdy_n(rdy_n), .ken_n(ken_n), .hold(hold), .hlda(hlda), .ads_n(ads_n),
    .cyc_def(cyc_def), .lock_n(lock_n), .plock_n(plock_n), .drv_en(drv_en),
    .line_fill(line_fill));

  task automatic chk(input int got, input int exp, input string what);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", what, got, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_txn(input int t, input int lk, input int nb, input int ws, input int kn);
    int eff;
    eff = (nb == 0) ? 1 : nb;
    req_valid = 1; req_type = 3'(t); req_lock = lk[0]; req_beats = 3'(nb);
    #1;
    chk(req_take, 1, "R2 req_take");
    chk(err, (t == 5) ? 1 : 0, "R3 err");
    tick;
    req_valid = 0;
    if (t == 5) begin
      chk(ads_n, 1, "R3 reserved starts no cycle");
      return;
    end
    for (int b = 0; b < eff; b++) begin
      chk(ads_n, 0, "R2 strobe low");
      chk(cyc_def, t, "R3 kind lines");
      chk(lock_n, lk ? 0 : 1, "R4 lock in address clock");
      chk(plock_n, (eff - b > 1) ? 0 : 1, "R5 pseudo-lock");
      tick;
      chk(ads_n, 1, "R2 strobe single clock");
      for (int w = 0; w < ws; w++) tick;
      rdy_n = 0; ken_n = kn[0];
      #1;
      chk(line_fill, (kn == 0 && lk == 0 && (t == 4 || t == 6)) ? 1 : 0, "R8 line fill");
      chk(lock_n, lk ? 0 : 1, "R4 lock in ready clock");
      tick;
      rdy_n = 1; ken_n = 1;
    end
    chk(ads_n, 1, (nb == 0) ? "R9 zero count runs once" : "R2 idle after last");
    chk(lock_n, 1, "R4 lock released");
    chk(plock_n, 1, "R5 pseudo-lock released");
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ads_n, 1, "R1 ads_n");
    chk(lock_n, 1, "R1 lock_n");
    chk(plock_n, 1, "R1 plock_n");
    chk(hlda, 0, "R1 hlda");
    chk(drv_en, 1, "R1 drv_en");
    chk(err, 0, "R1 err");
    rst_n = 1;
    tick;

    for (int t = 0; t < 8; t++)
      for (int lk = 0; lk < 2; lk++)
        for (int nb = 0; nb < 5; nb++)
          for (int ws = 0; ws < 2; ws++)
            run_txn(t, lk, nb, ws, (t + nb) % 2);

    // R6/R7: hold in idle beats a pending request
    hold = 1; req_valid = 1; req_type = 3'b110; req_lock = 0; req_beats = 3'd1;
    #1;
    chk(req_take, 0, "R6 hold has priority");
    tick;
    chk(hlda, 1, "R6 idle grant");
    chk(drv_en, 0, "R7 released");
    tick; tick;
    chk(hlda, 1, "R7 hlda kept");
    chk(ads_n, 1, "R7 no strobe while held");
    hold = 0; req_valid = 0;
    tick;
    chk(hlda, 0, "R7 hlda drops");
    chk(drv_en, 1, "R7 drive restored");

    // R6: locked two-cycle transaction defers hold
    req_valid = 1; req_type = 3'b111; req_lock = 1; req_beats = 3'd2;
    tick;
    req_valid = 0; hold = 1;
    tick;
    rdy_n = 0;
    tick;
    rdy_n = 1;
    chk(hlda, 0, "R6 no grant while locked");
    chk(ads_n, 0, "R6 second locked cycle runs");
    tick;
    rdy_n = 0;
    tick;
    rdy_n = 1;
    chk(hlda, 1, "R6 grant after last locked ready");
    chk(lock_n, 1, "R4 lock off at grant");
    hold = 0;
    tick;
    chk(hlda, 0, "R7 hlda drops");
    chk(ads_n, 1, "R7 nothing left to resume");

    // R6/R7: unlocked three-cycle transaction yields between cycles
    req_valid = 1; req_type = 3'b100; req_lock = 0; req_beats = 3'd3;
    tick;
    req_valid = 0; hold = 1;
    tick;
    rdy_n = 0;
    tick;
    rdy_n = 1;
    chk(hlda, 1, "R6 grant between unlocked cycles");
    chk(drv_en, 0, "R7 released mid transaction");
    chk(ads_n, 1, "R7 no strobe while held");
    tick;
    chk(hlda, 1, "R7 hlda kept");
    hold = 0;
    tick;
    chk(hlda, 0, "R7 hlda drops");
    chk(ads_n, 0, "R7 resume address");
    chk(plock_n, 0, "R5 pseudo-lock on resumed cycle");
    tick;
    rdy_n = 0;
    tick;
    rdy_n = 1;
    chk(ads_n, 0, "R2 final cycle address");
    chk(plock_n, 1, "R5 pseudo-lock off at final address");
    tick;
    rdy_n = 0;
    tick;
    rdy_n = 1;
    chk(ads_n, 1, "R2 idle after resumed transaction");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule